// File: doc/BRIEF.md
# E1 Transmit CAS Sampler and Inserter

This block sits in the transmit path of an E1 line, between the system highway and the framer. It reads a serial signaling stream that runs on the same bit clock as the outgoing PCM stream. Its frame position comes from a frame sync pulse, and a multiframe sync pulse ties its 16-frame count to the CRC4 multiframe.

The block samples the signaling stream only during frame 15, the last frame of each multiframe. From each ordinary timeslot it keeps the ABCD nibble, which is the last four bits of the slot. From timeslot 16 it keeps the whole byte. These captured values go into a shadow buffer. At the start of the next multiframe the shadow buffer is copied as a whole into the active buffer. The block then writes the active contents into timeslot 16 of the PCM stream:
- In frame 0 it sends the captured TS16 byte, which carries the multiframe alignment word.
- In frame n it sends channel n in the high nibble and channel n+16 in the low nibble.

A register write port holds an ABCD nibble and an ownership bit for each channel. An owned channel sends its register nibble instead of the sampled one. When insertion is disabled, the PCM stream passes through untouched.

Top module: `e1_cas_inserter`

## Requirements
- R1: While reset is asserted, `pcm_out` is 1. The shadow, active and register stores all clear to zero.
- R2: With `cas_en` low, `pcm_out` equals `pcm_in` delayed by one clock. This holds in every timeslot. Capture and buffer transfer keep running meanwhile.
- R3: With `cas_en` high, every bit outside timeslot 16 appears on `pcm_out` one clock after it arrives on `pcm_in`, unchanged.
- R4: A cycle with `fsync` high carries the first bit of timeslot 0 of a frame. Bits are sent MSB first and 8 bits make a timeslot. Each `fsync` advances the frame count modulo 16. `fsync` and `mfsync` high together mark frame 0.
- R5: `sig_in` is sampled only in frame 15. Its values in frames 0 to 14 have no effect on `pcm_out`.
- R6: In frame 15, bits 5 to 8 of timeslot n (n not 0 or 16) are stored as that channel's nibble, with A first and A as the MSB. Bits 1 to 4 of those slots are ignored. The timeslot 0 contents are ignored.
- R7: In frame 15 all 8 bits of timeslot 16 are stored. That byte is inserted MSB first into timeslot 16 of frame 0.
- R8: In frame n (1 to 15), timeslot 16 of `pcm_out` carries channel n's nibble in bits 1 to 4 and channel n+16's nibble in bits 5 to 8.
- R9: Data captured in the last frame of multiframe m is inserted throughout multiframe m+1, and only there.
- R10: When a channel's ownership bit is set, its register nibble is inserted in place of the sampled one.
- R11: A cycle with `reg_we` high writes `reg_abcd` and `reg_own` for timeslot `reg_ts`, and the write takes effect on the next clock. Clearing the ownership bit returns the channel to sampled data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | High on the first bit of each frame |
| mfsync | input | 1 | High with fsync on frame 0 of a multiframe |
| cas_en | input | 1 | Enables timeslot 16 insertion |
| pcm_in | input | 1 | Serial PCM data from the system side |
| sig_in | input | 1 | Serial signaling stream |
| reg_we | input | 1 | Register path write strobe |
| reg_ts | input | 5 | Timeslot addressed by the write |
| reg_abcd | input | 4 | ABCD nibble to store |
| reg_own | input | 1 | Ownership bit to store |
| pcm_out | output | 1 | Serial PCM data toward the framer |

## Verification
The bench sweeps six full multiframes bit by bit. It fills frames 0 to 14, the first half of each ordinary slot, and timeslot 0 of the signaling stream with random bits. A design that sampled outside frame 15, or sampled the wrong half of a slot, would then send random nibbles. It computes each expected timeslot 16 bit from the previous multiframe's pattern. This catches a design that copies the shadow buffer early or leaves the upper and lower channel halves swapped. It also changes ownership bits between multiframes, including clearing one. Register priority, and the return to sampled data after the bit is cleared, are therefore checked against the bench's own model.

// File: rtl/e1cas_pkg.sv
package e1cas_pkg;
    localparam int TS_BITS  = 8;
    localparam int NUM_TS   = 32;
    localparam int NUM_FRM  = 16;
    localparam int NIB_W    = TS_BITS / 2;
    localparam int FRM_LEN  = TS_BITS * NUM_TS;
    localparam int BIT_W    = $clog2(FRM_LEN);
    localparam int SLOT_W   = $clog2(TS_BITS);
    localparam int TS_W     = $clog2(NUM_TS);
    localparam int FRM_W    = $clog2(NUM_FRM);

    localparam logic [TS_W-1:0]  SIG_TS   = TS_W'(NUM_TS / 2);
    localparam logic [TS_W-1:0]  FAS_TS   = '0;
    localparam logic [FRM_W-1:0] FRM_LAST = FRM_W'(NUM_FRM - 1);

    typedef logic [NUM_TS-1:0][NIB_W-1:0] nib_bank_t;
    typedef logic [TS_BITS-1:0]            slot_byte_t;

    typedef struct packed {
        logic [BIT_W-1:0] bit_idx;
        logic [FRM_W-1:0] frame;
    } pos_t;
endpackage

// File: rtl/e1cas_timing.sv
module e1cas_timing
    import e1cas_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic mfsync,
    output pos_t cur,
    output logic last_frame,
    output logic mf_start
);
    pos_t pos_d, pos_q;

    always_comb begin
        pos_d = pos_q;
        pos_d.bit_idx = fsync ? '0 : pos_q.bit_idx + 1'b1;
        if (fsync && mfsync)
            pos_d.frame = '0;
        else if (pos_d.bit_idx == '0)
            pos_d.frame = pos_q.frame + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q.bit_idx <= '1;
            pos_q.frame   <= '1;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign cur        = pos_d;
    assign last_frame = (pos_d.frame == FRM_LAST);
    assign mf_start   = (pos_d.frame == '0) && (pos_d.bit_idx == '0);
endmodule

// File: rtl/e1cas_capture.sv
module e1cas_capture
    import e1cas_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_in,
    input  pos_t       cur,
    input  logic       last_frame,
    input  logic       mf_start,
    output nib_bank_t  act_nib,
    output slot_byte_t act_b16
);
    typedef struct packed {
        nib_bank_t  sh_nib;
        slot_byte_t sh_b16;
        nib_bank_t  ac_nib;
        slot_byte_t ac_b16;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [TS_W-1:0]   ts;
    logic [SLOT_W-1:0] k;

    assign ts = cur.bit_idx[BIT_W-1:SLOT_W];
    assign k  = cur.bit_idx[SLOT_W-1:0];

    always_comb begin
        cap_d = cap_q;
        if (last_frame) begin
            if (ts == SIG_TS)
                cap_d.sh_b16[~k] = sig_in;
            else if (ts != FAS_TS && k[SLOT_W-1])
                cap_d.sh_nib[ts][~k[SLOT_W-2:0]] = sig_in;
        end
        if (mf_start) begin
            cap_d.ac_nib = cap_q.sh_nib;
            cap_d.ac_b16 = cap_q.sh_b16;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cap_q <= '0;
        else
            cap_q <= cap_d;
    end

    assign act_nib = cap_q.ac_nib;
    assign act_b16 = cap_q.ac_b16;

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_frame |=> ($stable(cap_q.sh_nib) && $stable(cap_q.sh_b16)));

    // R9
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_start |=> ($stable(cap_q.ac_nib) && $stable(cap_q.ac_b16)));
endmodule

// File: rtl/e1cas_regbank.sv
module e1cas_regbank
    import e1cas_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [TS_W-1:0]    ts,
    input  logic [NIB_W-1:0]   abcd,
    input  logic               own,
    output nib_bank_t          reg_nib,
    output logic [NUM_TS-1:0]  own_mask
);
    typedef struct packed {
        nib_bank_t          nib;
        logic [NUM_TS-1:0]  mask;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        rb_d = rb_q;
        if (we && ts != FAS_TS && ts != SIG_TS) begin
            rb_d.nib[ts]  = abcd;
            rb_d.mask[ts] = own;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rb_q <= '0;
        else
            rb_q <= rb_d;
    end

    assign reg_nib  = rb_q.nib;
    assign own_mask = rb_q.mask;

    // R11
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rb_q));
endmodule

// File: rtl/e1cas_insert.sv
module e1cas_insert
    import e1cas_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cas_en,
    input  logic               pcm_in,
    input  pos_t               cur,
    input  nib_bank_t          act_nib,
    input  slot_byte_t         act_b16,
    input  nib_bank_t          reg_nib,
    input  logic [NUM_TS-1:0]  own_mask,
    output logic               pcm_out
);
    typedef struct packed {
        logic dout;
    } ins_t;

    ins_t ins_d, ins_q;
    logic [TS_W-1:0]   ts;
    logic [SLOT_W-1:0] k;
    logic [TS_W-1:0]   ch;
    logic [NIB_W-1:0]  nib;
    logic              sig_bit;

    assign ts = cur.bit_idx[BIT_W-1:SLOT_W];
    assign k  = cur.bit_idx[SLOT_W-1:0];
    // Upper half of the slot carries channel n+16, i.e. the top channel bit set.
    assign ch = {k[SLOT_W-1], cur.frame};

    always_comb begin
        nib     = own_mask[ch] ? reg_nib[ch] : act_nib[ch];
        sig_bit = (cur.frame == '0) ? act_b16[~k] : nib[~k[SLOT_W-2:0]];
        ins_d      = ins_q;
        ins_d.dout = (cas_en && ts == SIG_TS) ? sig_bit : pcm_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ins_q.dout <= 1'b1;
        else
            ins_q <= ins_d;
    end

    assign pcm_out = ins_q.dout;

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_en |=> (pcm_out == $past(pcm_in)));

    // R3
    non_sig_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_en && ts != SIG_TS) |=> (pcm_out == $past(pcm_in)));
endmodule

// File: rtl/e1_cas_inserter.sv
module e1_cas_inserter
    import e1cas_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             mfsync,
    input  logic             cas_en,
    input  logic             pcm_in,
    input  logic             sig_in,
    input  logic             reg_we,
    input  logic [TS_W-1:0]  reg_ts,
    input  logic [NIB_W-1:0] reg_abcd,
    input  logic             reg_own,
    output logic             pcm_out
);
    pos_t              cur;
    logic              last_frame;
    logic              mf_start;
    nib_bank_t         act_nib;
    slot_byte_t        act_b16;
    nib_bank_t         reg_nib;
    logic [NUM_TS-1:0] own_mask;

    e1cas_timing u_timing (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .mfsync     (mfsync),
        .cur        (cur),
        .last_frame (last_frame),
        .mf_start   (mf_start)
    );

    e1cas_capture u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_in     (sig_in),
        .cur        (cur),
        .last_frame (last_frame),
        .mf_start   (mf_start),
        .act_nib    (act_nib),
        .act_b16    (act_b16)
    );

    e1cas_regbank u_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .ts       (reg_ts),
        .abcd     (reg_abcd),
        .own      (reg_own),
        .reg_nib  (reg_nib),
        .own_mask (own_mask)
    );

    e1cas_insert u_insert (
        .clk      (clk),
        .rst_n    (rst_n),
        .cas_en   (cas_en),
        .pcm_in   (pcm_in),
        .cur      (cur),
        .act_nib  (act_nib),
        .act_b16  (act_b16),
        .reg_nib  (reg_nib),
        .own_mask (own_mask),
        .pcm_out  (pcm_out)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!rst_n || $past(pcm_out) == 1'b1));
endmodule

// File: tb/e1_cas_inserter_tb.sv
module e1_cas_inserter_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       mfsync = 1'b0;
    logic       cas_en = 1'b0;
    logic       pcm_in = 1'b0;
    logic       sig_in = 1'b0;
    logic       reg_we = 1'b0;
    logic [4:0] reg_ts = '0;
    logic [3:0] reg_abcd = '0;
    logic       reg_own = 1'b0;
    logic       pcm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int model_val [32];
    int model_own [32];

    always #10 clk = ~clk;

    e1_cas_inserter u_dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .mfsync(mfsync),
        .cas_en(cas_en), .pcm_in(pcm_in), .sig_in(sig_in),
        .reg_we(reg_we), .reg_ts(reg_ts), .reg_abcd(reg_abcd),
        .reg_own(reg_own), .pcm_out(pcm_out)
    );

    function automatic int nib_of(int m, int ts);
        return (ts * 5 + m * 3 + 1) & 15;
    endfunction

    function automatic int b16_of(int m);
        return (m * 37 + 11) & 255;
    endfunction

    task automatic check(logic got, logic exp, string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: pcm_out got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic  prev_exp;
        string prev_tag;
        bit    have_prev;

        for (int i = 0; i < 32; i++) begin
            model_val[i] = 0;
            model_own[i] = 0;
        end

        // R1: idle output during reset
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(pcm_out, 1'b1, "R1");
        end
        rst_n = 1'b1;

        // Free-running period with no sync, insertion off: plain bypass (R2)
        have_prev = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (have_prev) check(pcm_out, prev_exp, prev_tag);
            pcm_in    = 1'($urandom);
            sig_in    = 1'($urandom);
            prev_exp  = pcm_in;
            prev_tag  = "R2";
            have_prev = 1'b1;
        end

        // R4: fsync/mfsync now re-align the position counters
        for (int m = 0; m < 6; m++) begin
            for (int f = 0; f < 16; f++) begin
                for (int b = 0; b < 256; b++) begin
                    int  ts;
                    int  k;
                    int  ch;
                    int  nib;
                    logic exp;
                    string tag;
                    @(negedge clk);
                    if (have_prev) check(pcm_out, prev_exp, prev_tag);
                    ts = b / 8;
                    k  = b % 8;
                    fsync  = (b == 0);
                    mfsync = (b == 0) && (f == 0);
                    cas_en = (m != 0);
                    pcm_in = 1'($urandom);
                    // R5 R6: only frame 15, TS16 in full, other slots upper half
                    if (f == 15 && ts == 16)
                        sig_in = 1'((b16_of(m) >> (7 - k)) & 1);
                    else if (f == 15 && ts != 0 && k >= 4)
                        sig_in = 1'((nib_of(m, ts) >> (7 - k)) & 1);
                    else
                        sig_in = 1'($urandom);

                    reg_we = 1'b0;
                    if (f == 0 && b == 5 && m == 2) begin
                        reg_we = 1'b1; reg_ts = 5'd3;  reg_abcd = 4'hA; reg_own = 1'b1;
                    end else if (f == 0 && b == 6 && m == 2) begin
                        reg_we = 1'b1; reg_ts = 5'd20; reg_abcd = 4'h5; reg_own = 1'b1;
                    end else if (f == 0 && b == 5 && m == 4) begin
                        reg_we = 1'b1; reg_ts = 5'd3;  reg_abcd = 4'h0; reg_own = 1'b0;
                    end else if (f == 0 && b == 5 && m == 5) begin
                        reg_we = 1'b1; reg_ts = 5'd31; reg_abcd = 4'hF; reg_own = 1'b1;
                    end
                    if (reg_we) begin
                        model_val[reg_ts] = int'(reg_abcd);
                        model_own[reg_ts] = int'(reg_own);
                    end

                    if (!cas_en) begin
                        exp = pcm_in; tag = "R2";
                    end else if (ts != 16) begin
                        exp = pcm_in; tag = "R3";
                    end else if (f == 0) begin
                        exp = 1'((b16_of(m - 1) >> (7 - k)) & 1); tag = "R7/R9";
                    end else begin
                        ch = (k < 4) ? f : f + 16;
                        if (model_own[ch] != 0) begin
                            nib = model_val[ch]; tag = "R10";
                        end else begin
                            nib = nib_of(m - 1, ch);
                            tag = (ch == 3 && m >= 4) ? "R11" : "R5/R6/R8/R9";
                        end
                        exp = 1'((nib >> (3 - (k % 4))) & 1);
                    end
                    prev_exp  = exp;
                    prev_tag  = tag;
                    have_prev = 1'b1;
                end
            end
        end
        @(negedge clk);
        check(pcm_out, prev_exp, prev_tag);
        finish_run();
    end
endmodule